// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one group of sixteen lane addresses at a time, with a lane enable mask and one access size shared by every lane. It checks whether the group forms a single aligned, contiguous block of memory. If it does, the block sends one wide burst request to the memory controller. If it does not, the block sends one narrow request for each enabled lane. It does not handle returned data.

The input side and the request side are both valid/ready streams. A group is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low while any request from the held group is still outstanding. On the request side, a request stays on the port without change until `req_ready` takes it. `req_ready` may be held low for as long as the controller needs. `grp_coalesced` is a plain status output that shows how the last accepted group was served.

Size code encoding on `in_size`:

| Code | Bytes per lane |
|------|----------------|
| 0 | 4 |
| 1 | 8 |
| 2 | 16 |
| 3 | 32 (never merged) |

Lane n's address sits at bits [n·32 +: 32] of `in_addr`. Bit n of `in_en` enables lane n.

Top module: `hw_coalescer`

## Requirements
- R1: When no group is held, `in_ready` is high. A group is captured on a rising edge where `in_valid` and `in_ready` are both high. Size codes 0, 1 and 2 mean 4, 8 and 16 bytes per lane.
- R2: A group is merged only if all of the following hold: the size code is not 3, at least one lane is enabled, and every enabled lane n addresses lane 0's address plus n times the lane size.
- R3: A group is merged only if lane 0's address is a multiple of 16 times the lane size.
- R4: A merged group produces exactly one request with these fields: `req_addr` is lane 0's address, `req_bytes` is 16 times the lane size, `req_lane` is 0 and `req_burst` is 1.
- R5: A group that is not merged produces one request per enabled lane, in ascending lane order. Each request carries that lane's address, `req_bytes` equal to the lane size (4 shifted left by the code, so 32 for code 3), `req_lane` set to the lane index, and `req_burst` set to 0.
- R6: The address of a disabled lane plays no part in the merge check. A disabled lane gets no request of its own.
- R7: While `req_valid` is high and `req_ready` is low, the request stays valid and its address, byte count and lane index do not change.
- R8: After a group with at least one enabled lane is accepted, `in_ready` goes low. It stays low until the cycle after the group's last request is accepted, and it is high again in that cycle.
- R9: `grp_coalesced` takes the merge decision of each accepted group in the cycle after acceptance and holds it until the next group is accepted. It is 0 after reset.
- R10: A group with no enabled lanes is accepted and produces no request. `in_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Block can take a group |
| in_addr | input | 512 | Sixteen 32-bit lane addresses, lane n at [n·32 +: 32] |
| in_en | input | 16 | Lane enable mask |
| in_size | input | 2 | Lane size code (0:4 B, 1:8 B, 2:16 B, 3:32 B) |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Controller takes the request |
| req_addr | output | 32 | Request start address |
| req_bytes | output | 10 | Request length in bytes |
| req_lane | output | 4 | Lane served (0 for a burst) |
| req_burst | output | 1 | Request is a merged burst |
| grp_coalesced | output | 1 | Last accepted group was merged |

## Verification
The assertions check four things on every cycle:
- A stalled request stays stable.
- Each burst's start address is aligned to its own length.
- Per-lane requests come out in strictly ascending lane order.
- A burst ends its group, and both empty and non-empty groups have the right effect on acceptance.

The bench checks the points that need a reference model. It confirms that the merge decision matches the arithmetic rule and that each request carries the right address, length and lane. It also confirms that no request is lost or duplicated across groups that are misaligned, broken in one lane, partly enabled, reversed or random, for every size code and under random back-pressure.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef logic [1:0] size_code_t;
  localparam size_code_t SIZE_CODE_WIDE = 2'd3;

  function automatic int unsigned lane_bytes(size_code_t c);
    return 32'd4 << c;
  endfunction
endpackage

// File: rtl/hwc_match.sv
module hwc_match #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    en,
  input  hwc_pkg::size_code_t size_code,
  output logic                mergeable
);
  logic [AW-1:0]    base;
  logic [2:0]       shift;
  logic [AW-1:0]    align_mask;
  logic [LANES-1:0] lane_ok;

  assign base       = addr[AW-1:0];
  assign shift      = {1'b0, size_code} + 3'd2;
  assign align_mask = (AW'(LANES) << shift) - AW'(1);

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign lane_ok[n] = !en[n] || (addr[n*AW +: AW] == base + (AW'(n) << shift));
  end

  assign mergeable = (size_code != hwc_pkg::SIZE_CODE_WIDE) && ((base & align_mask) == '0)
                     && (&lane_ok) && (|en);
endmodule

// File: rtl/hwc_pick.sv
module hwc_pick #(
  parameter int LANES = 16,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] mask,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/hwc_seq.sv
module hwc_seq #(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int IDX_W = $clog2(LANES),
  localparam int BW    = $clog2(LANES * 32) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*AW-1:0] in_addr,
  input  logic [LANES-1:0]    in_en,
  input  hwc_pkg::size_code_t in_size,
  input  logic                merge_in,
  output logic [LANES-1:0]    pend_o,
  input  logic [IDX_W-1:0]    pick_idx,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [AW-1:0]       req_addr,
  output logic [BW-1:0]       req_bytes,
  output logic [IDX_W-1:0]    req_lane,
  output logic                req_burst,
  output logic                grp_coalesced
);
  logic [LANES-1:0][AW-1:0] addr_q;
  hwc_pkg::size_code_t      size_q;
  logic [LANES-1:0]         pend_q;
  logic                     merge_q;
  logic                     accept;
  logic                     take;

  assign in_ready  = ~(|pend_q);
  assign accept    = in_valid && in_ready;
  assign req_valid = |pend_q;
  assign take      = req_valid && req_ready;
  assign pend_o    = pend_q;
  assign req_burst = req_valid && merge_q;
  assign req_lane  = merge_q ? '0 : pick_idx;
  assign req_addr  = addr_q[req_lane];
  assign req_bytes = merge_q ? BW'(hwc_pkg::lane_bytes(size_q) * LANES)
                             : BW'(hwc_pkg::lane_bytes(size_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q        <= '0;
      merge_q       <= 1'b0;
      grp_coalesced <= 1'b0;
      size_q        <= '0;
      addr_q        <= '0;
    end else if (accept) begin
      addr_q        <= in_addr;
      size_q        <= in_size;
      merge_q       <= merge_in;
      grp_coalesced <= merge_in;
      pend_q        <= merge_in ? LANES'(1) : in_en;
    end else if (take) begin
      pend_q <= merge_q ? '0 : (pend_q & ~(LANES'(1) << pick_idx));
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_bytes) && $stable(req_lane)); // R7
  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_burst |-> ((req_addr & AW'(req_bytes - BW'(1))) == '0)); // R3
  AST_LANES_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_burst |=> !req_valid || (req_lane > $past(req_lane))); // R5
  AST_BURST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_burst |=> !req_valid); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (|in_en) |=> !in_ready); // R8
  AST_EMPTY_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !(|in_en) |=> !req_valid && in_ready); // R10
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer #(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int IDX_W = $clog2(LANES),
  localparam int BW    = $clog2(LANES * 32) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*AW-1:0] in_addr,
  input  logic [LANES-1:0]    in_en,
  input  logic [1:0]          in_size,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [AW-1:0]       req_addr,
  output logic [BW-1:0]       req_bytes,
  output logic [IDX_W-1:0]    req_lane,
  output logic                req_burst,
  output logic                grp_coalesced
);
  logic             mergeable;
  logic [LANES-1:0] pend;
  logic [IDX_W-1:0] first_lane;

  hwc_match #(.LANES(LANES), .AW(AW)) i_match (
    .addr(in_addr), .en(in_en), .size_code(in_size), .mergeable(mergeable)
  );

  hwc_pick #(.LANES(LANES)) i_pick (
    .mask(pend), .idx(first_lane)
  );

  hwc_seq #(.LANES(LANES), .AW(AW)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_en(in_en), .in_size(in_size),
    .merge_in(mergeable), .pend_o(pend), .pick_idx(first_lane),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_lane(req_lane),
    .req_burst(req_burst), .grp_coalesced(grp_coalesced)
  );
endmodule

// File: tb/test_hw_coalescer.sv
module test_hw_coalescer;
  localparam int LANES = 16;
  localparam int AW    = 32;
  localparam int BW    = 10;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [LANES-1:0]    in_en = '0;
  logic [1:0]          in_size = '0;
  logic                req_valid;
  logic                req_ready = 1'b0;
  logic [AW-1:0]       req_addr;
  logic [BW-1:0]       req_bytes;
  logic [3:0]          req_lane;
  logic                req_burst;
  logic                grp_coalesced;

  always #2 clk = ~clk;

  hw_coalescer i_hw_coalescer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_en(in_en), .in_size(in_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_lane(req_lane), .req_burst(req_burst),
    .grp_coalesced(grp_coalesced)
  );

  int vectors = 0;
  int errors  = 0;
  logic [31:0] rs = 32'h1234_5678;
  logic [AW-1:0] g_addr [LANES];
  logic [LANES-1:0] g_en;
  logic [1:0] g_sz;

  logic [AW-1:0] e_addr [LANES];
  int            e_bytes [LANES];
  int            e_lane [LANES];
  logic          e_burst [LANES];
  int            e_n;
  logic          e_coal;

  function automatic logic [31:0] rnd_next(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic roll();
    rs = rnd_next(rs);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_expect();
    longint sz = longint'(4) << g_sz;
    logic [AW-1:0] base = g_addr[0];
    e_coal = (g_sz != 2'd3) && (g_en != '0) && ((base % (sz * 16)) == 0);
    for (int n = 0; n < LANES; n++)
      if (g_en[n] && (g_addr[n] != AW'(base + sz * n))) e_coal = 1'b0;
    e_n = 0;
    if (e_coal) begin
      e_addr[0] = base; e_bytes[0] = int'(sz * 16); e_lane[0] = 0; e_burst[0] = 1'b1; e_n = 1;
    end else begin
      for (int n = 0; n < LANES; n++) if (g_en[n]) begin
        e_addr[e_n] = g_addr[n]; e_bytes[e_n] = int'(sz); e_lane[e_n] = n; e_burst[e_n] = 1'b0;
        e_n++;
      end
    end
  endtask

  task automatic run_group();
    int idx = 0;
    int waitc = 0;
    logic stalled = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    build_expect();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready idle", in_ready, 1);
    in_valid = 1'b1; in_en = g_en; in_size = g_sz;
    for (int n = 0; n < LANES; n++) in_addr[n*AW +: AW] = g_addr[n];
    @(negedge clk);
    in_valid = 1'b0;
    chk(grp_coalesced == e_coal, "R2/R3/R9 merge decision", grp_coalesced, e_coal);
    if (e_n > 0) chk(in_ready == 1'b0, "R8 busy after accept", in_ready, 0);
    else chk(req_valid == 1'b0 && in_ready == 1'b1, "R10 empty group", {req_valid, in_ready}, 1);
    while (idx < e_n && waitc < 400) begin
      roll();
      req_ready = rs[0] | rs[1];
      #1;
      if (stalled) chk(req_valid && req_addr == prev_addr, "R7 stall hold", req_addr, prev_addr);
      if (req_valid && req_ready) begin
        if (e_burst[idx])
          chk(req_addr == e_addr[idx] && req_bytes == BW'(e_bytes[idx]) && req_lane == 4'(e_lane[idx]) && req_burst,
              "R4 burst request", {req_addr, 6'(req_bytes), req_lane}, {e_addr[idx], 6'(e_bytes[idx]), 4'(e_lane[idx])});
        else
          chk(req_addr == e_addr[idx] && req_bytes == BW'(e_bytes[idx]) && req_lane == 4'(e_lane[idx]) && !req_burst,
              "R5/R6 lane request", {req_addr, 6'(req_bytes), req_lane}, {e_addr[idx], 6'(e_bytes[idx]), 4'(e_lane[idx])});
        if (idx + 1 < e_n) chk(in_ready == 1'b0, "R8 busy mid group", in_ready, 0);
        idx++;
      end
      stalled = req_valid && !req_ready;
      prev_addr = req_addr;
      @(negedge clk);
      waitc++;
    end
    req_ready = 1'b0;
    chk(idx == e_n, "R5 request count", idx, e_n);
    #1;
    chk(req_valid == 1'b0 && in_ready == 1'b1, "R8 ready after last", {req_valid, in_ready}, 1);
    chk(grp_coalesced == e_coal, "R9 status held", grp_coalesced, e_coal);
  endtask

  task automatic make_group(input int sz, input int pat);
    logic [AW-1:0] step = AW'(4) << sz;
    logic [AW-1:0] base;
    roll();
    base = rs & ~((AW'(64) << sz) - AW'(1));
    g_sz = 2'(sz);
    g_en = '1;
    for (int n = 0; n < LANES; n++) g_addr[n] = base + step * AW'(n);
    case (pat)
      1: for (int n = 0; n < LANES; n++) g_addr[n] = g_addr[n] + step;
      2: g_addr[7] = g_addr[7] + step;
      3: begin roll(); g_en = rs[15:0]; g_en[7] = 1'b0; g_addr[7] = g_addr[7] ^ 32'h100; end
      4: g_en = '0;
      5: begin g_en[0] = 1'b0; end
      6: for (int n = 0; n < LANES; n++) g_addr[n] = base + step * AW'(LANES - 1 - n);
      7: begin
        for (int n = 0; n < LANES; n++) begin roll(); g_addr[n] = rs; end
        roll(); g_en = rs[31:16];
      end
      default: ;
    endcase
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && req_valid == 1'b0, "R1 reset idle", {in_ready, req_valid}, 2);
    chk(grp_coalesced == 1'b0, "R9 reset status", grp_coalesced, 0);
    for (int round = 0; round < 3; round++)
      for (int sz = 0; sz < 4; sz++)
        for (int pat = 0; pat < 8; pat++) begin
          make_group(sz, pat);
          run_group();
        end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule